// File: doc/BRIEF.md
# 1-Wire Device Bit-Slot Engine

This block is the bit-level front end of a device on a single open-drain 1-Wire line that an external resistor pulls high. The master opens every time slot by driving the line low. The block detects that falling edge and measures time from it by counting a one-microsecond tick. A local mode input, latched at the edge, says what the slot is for.

In a receive slot the block samples the line once, a fixed number of ticks after the edge. It reports the bit on a registered output together with a strobe one clock wide. In a transmit slot it sends the latched transmit bit. A one needs no action. A zero is sent by driving the pull-low enable from the edge for a fixed number of ticks, which covers the point where the master samples the line. The block then lets go so that the resistor can restore the high level. Once a slot is over, the block waits for the line to read high before it accepts a new falling edge.

The line input passes through a synchronizer, so it may be driven asynchronously. Reset and presence signalling, command decoding and storage belong to other blocks.

Top module: `ow_slot_responder`

## Requirements
- R1: After reset the pull-low enable is 0, the received-bit strobe is 0 and the received bit is 0.
- R2: In a receive slot (tx_mode = 0 when the slot opens), a line that reads high at the sample point is reported as rx_bit_o = 1.
- R3: In a receive slot, a line that reads low at the sample point is reported as rx_bit_o = 0.
- R4: Each receive slot produces exactly one rx_valid_o pulse, one clock wide.
- R5: In a transmit slot whose latched bit is 1, pull_low_o stays 0 for the whole slot.
- R6: pull_low_o rises only in a transmit slot whose latched bit is 0 (tx_mode = 1 and tx_bit = 0 in the clock where the slot opens). It is asserted while the master samples, 15 ticks after the edge.
- R7: pull_low_o is released after HOLD_US ticks, so it is never high for more than HOLD_US ticks.
- R8: A transmit slot never produces rx_valid_o, and rx_valid_o and pull_low_o are never high together.
- R9: Falling edges that occur while a slot is in progress do not open a new slot and do not add a strobe.
- R10: tx_mode and tx_bit are latched when the slot opens. Changing them during the slot has no effect on that slot.
- R11: The receive sample is taken at the SAMPLE_US-th tick after the edge. A master low that ends two or more ticks before that tick gives 1, and one that lasts two or more ticks past it gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Line level as read from the open-drain pad, asynchronous |
| us_tick | input | 1 | One-clock pulse every microsecond |
| tx_mode | input | 1 | 1 = next slot is a transmit slot, 0 = receive slot |
| tx_bit | input | 1 | Bit to send in the next transmit slot |
| pull_low_o | output | 1 | Enable for the pad's pull-down driver |
| rx_bit_o | output | 1 | Last bit received |
| rx_valid_o | output | 1 | One-clock strobe when rx_bit_o is updated |

## Verification
The assertions assume that us_tick is a single-clock pulse and that slots are long enough for the block to reach its idle state before the master opens the next one. The bench gives the master low phase in whole ticks and leaves an idle gap of several ticks between slots, so every slot starts from idle. The receive sweep leaves out low durations within one tick of the sample point. That boundary is blurred by the synchronizer latency and by the phase of the tick, so every duration the bench does use has a single correct answer.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SLOT    = 2'd1,
    ST_RECOVER = 2'd2
  } ow_state_t;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ow_fall_det.sv
module ow_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level;
  end

  assign fall = level_q & ~level;
endmodule

// File: rtl/ow_tick_cnt.sv
module ow_tick_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear)            count <= '0;
    else if (tick && ~&count)    count <= count + 1'b1;
  end
endmodule

// File: rtl/ow_slot_responder.sv
module ow_slot_responder #(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_US   = 30,
  parameter int HOLD_US     = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic us_tick,
  input  logic tx_mode,
  input  logic tx_bit,
  output logic pull_low_o,
  output logic rx_bit_o,
  output logic rx_valid_o
);
  import ow_pkg::*;

  localparam int MAX_US = (SAMPLE_US > HOLD_US) ? SAMPLE_US : HOLD_US;
  localparam int CW     = $clog2(MAX_US + 1);
  localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_US - 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_US - 1);

  ow_state_t     state;
  logic          line_s;
  logic          fall;
  logic [CW-1:0] elapsed;
  logic          mode_q;
  logic          bit_q;
  logic          sample_hit;
  logic          hold_hit;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_i),
    .q   (line_s)
  );

  ow_fall_det u_fall (
    .clk   (clk),
    .rst   (rst),
    .level (line_s),
    .fall  (fall)
  );

  ow_tick_cnt #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (state == ST_IDLE),
    .tick  (us_tick && state == ST_SLOT),
    .count (elapsed)
  );

  assign sample_hit = us_tick && (elapsed == SAMPLE_LAST);
  assign hold_hit   = us_tick && (elapsed == HOLD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mode_q     <= 1'b0;
      bit_q      <= 1'b1;
      pull_low_o <= 1'b0;
      rx_bit_o   <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall) begin
            state      <= ST_SLOT;
            mode_q     <= tx_mode;
            bit_q      <= tx_bit;
            pull_low_o <= tx_mode & ~tx_bit;
          end
        end
        ST_SLOT: begin
          if (!mode_q) begin
            if (sample_hit) begin
              rx_bit_o   <= line_s;
              rx_valid_o <= 1'b1;
              state      <= ST_RECOVER;
            end
          end else if (hold_hit) begin
            pull_low_o <= 1'b0;
            state      <= ST_RECOVER;
          end
        end
        ST_RECOVER: begin
          if (line_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_bit;
  assign unused_bit = bit_q;
endmodule

// File: rtl/ow_slot_responder_chk.sv
module ow_slot_responder_chk #(
  parameter int HOLD_US = 30
) (
  input logic clk,
  input logic rst,
  input logic us_tick,
  input logic tx_mode,
  input logic tx_bit,
  input logic pull_low_o,
  input logic rx_valid_o
);
  localparam int PW = $clog2(HOLD_US + 2);
  logic [PW-1:0] pull_ticks;

  always_ff @(posedge clk) begin
    if (rst || !pull_low_o)             pull_ticks <= '0;
    else if (us_tick && ~&pull_ticks)   pull_ticks <= pull_ticks + 1'b1;
  end

  // R4
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid_o && pull_low_o));

  // R6
  pull_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_low_o) |-> ($past(tx_mode) && !$past(tx_bit)));

  // R7
  pull_len_chk: assert property (@(posedge clk) disable iff (rst)
    pull_ticks <= PW'(HOLD_US));
endmodule

bind ow_slot_responder ow_slot_responder_chk #(.HOLD_US(HOLD_US)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .us_tick    (us_tick),
  .tx_mode    (tx_mode),
  .tx_bit     (tx_bit),
  .pull_low_o (pull_low_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/sim_ow_slot_responder.sv
module sim_ow_slot_responder;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int SAMPLE     = 30;
  localparam int HOLD       = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic tx_mode = 1'b0;
  logic tx_bit = 1'b1;
  logic us_tick;
  logic line_i;
  logic pull_low_o, rx_bit_o, rx_valid_o;
  logic [3:0] tdiv = '0;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  int pclk   = 0;
  logic last_bit = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tdiv <= (tdiv == 4'(DIV-1)) ? 4'd0 : tdiv + 4'd1;
  assign us_tick = (tdiv == 4'd0);
  assign line_i  = ~(master_low | pull_low_o);

  ow_slot_responder #(.SAMPLE_US(SAMPLE), .HOLD_US(HOLD)) u0 (
    .clk(clk), .rst(rst), .line_i(line_i), .us_tick(us_tick),
    .tx_mode(tx_mode), .tx_bit(tx_bit),
    .pull_low_o(pull_low_o), .rx_bit_o(rx_bit_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      vcount++;
      last_bit = rx_bit_o;
    end
    if (pull_low_o) pclk++;
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Receive slot: master low for low_ticks, optional extra pulse inside the slot.
  task automatic write_slot(int low_ticks, bit extra, int exp_bit, string req);
    tx_mode = 1'b0;
    vcount = 0;
    master_low = 1'b1;
    step(low_ticks * DIV);
    master_low = 1'b0;
    if (extra) begin
      step(3 * DIV);
      master_low = 1'b1;
      step(2 * DIV);
      master_low = 1'b0;
    end
    step(70 * DIV);
    check({req, " rx_bit"}, int'(last_bit), exp_bit);
    check("R4 single strobe", vcount, 1);
  endtask

  // Transmit slot; optionally flip mode and bit during the slot.
  task automatic read_slot(bit b, int low_ticks, bit flip);
    tx_mode = 1'b1;
    tx_bit = b;
    vcount = 0;
    pclk = 0;
    master_low = 1'b1;
    step(low_ticks * DIV);
    master_low = 1'b0;
    if (flip) begin
      tx_mode = 1'b0;
      tx_bit = ~b;
    end
    step((15 - low_ticks) * DIV);
    check(flip ? "R10 master sample" : (b ? "R5 master sample" : "R6 master sample"),
          int'(line_i), int'(b));
    step(55 * DIV);
    check("R8 no strobe in transmit slot", vcount, 0);
    if (b) check("R5 no pull", pclk, 0);
    else   check_range("R7 pull length", pclk, (HOLD-1)*DIV, HOLD*DIV + 1);
    tx_mode = 1'b1;
    tx_bit = 1'b1;
    step(5 * DIV);
  endtask

  initial begin
    step(5);
    check("R1 pull_low after reset", int'(pull_low_o), 0);
    check("R1 rx_valid after reset", int'(rx_valid_o), 0);
    check("R1 rx_bit after reset", int'(rx_bit_o), 0);
    rst = 1'b0;
    step(5 * DIV);

    for (int L = 1; L <= 40; L++) begin
      if (L >= SAMPLE-1 && L <= SAMPLE+1) continue;
      write_slot(L, 1'b0, (L <= SAMPLE-2) ? 1 : 0,
                 (L <= SAMPLE-2) ? "R2 R11" : "R3 R11");
      step(5 * DIV);
    end

    // R9: extra falling edge inside a receive slot is ignored.
    write_slot(2, 1'b1, 1, "R9");
    step(5 * DIV);

    for (int L = 1; L <= 3; L++) begin
      read_slot(1'b0, L, 1'b0);
      read_slot(1'b1, L, 1'b0);
    end
    read_slot(1'b0, 1, 1'b1);
    read_slot(1'b1, 2, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule